// File: doc/BRIEF.md
# Separable 3x3 Box Blur Stream Filter

The block is a streaming image filter that smooths a raster of 16-bit unsigned pixels with a 3x3 box kernel. The kernel is split into two passes. A horizontal pass averages each pixel with its left and right neighbours in the same row. A vertical pass then averages three such row results taken from the same column in consecutive rows. Each pass truncates its integer quotient by three. Rows have a fixed width set by the parameter `W`. The number of rows is open-ended: the filter keeps running for as long as pixels arrive.

Pixels enter one per cycle on a valid/ready stream in raster order. Two row-length stores of horizontal results sit between the passes. They supply the two rows above the current one. Kernel positions that would reach past the tile edge produce no output. These are the first and last column of every row, the first row, and the most recent row. Results leave on a valid/ready stream with a flag on the last result of each row. Output backpressure freezes the whole pipeline.

Top module: `box_blur3x3`

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: Sums are formed wide enough for three full-scale values. A 3x3 neighbourhood of 65535 yields an output of 65535.
- R3: The horizontal result at column x, row y is h(x,y) = floor((p(x-1,y)+p(x,y)+p(x+1,y))/3). The output for centre (x,y) is floor((h(x,y-1)+h(x,y)+h(x,y+1))/3). Outputs are emitted in raster order of their centres.
- R4: Only interior centres are emitted: x from 1 to W-2 and y from 1 upward. The result for centre row y appears while row y+1 is being accepted. For N input rows there are exactly (N-2)*(W-2) outputs.
- R5: `out_last` is 1 exactly on the output for column W-2 of each row. After that output is taken, `out_valid` is 0 in the next cycle.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` and `out_last` do not change. No output is lost or duplicated.
- R7: `in_ready` equals `!out_valid || out_ready`. An input is consumed only on a cycle where `in_valid` and `in_ready` are both 1.
- R8: The filter runs across any number of rows, reusing its row stores without a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Filter accepts a pixel this cycle |
| in_data | input | DW | Input pixel |
| out_valid | output | 1 | Output result present |
| out_ready | input | 1 | Downstream accepts a result |
| out_data | output | DW | Filtered result |
| out_last | output | 1 | Result is the last one of its row |

## Verification
The assertions check the stall contract on every cycle: a held result stays valid and unchanged. They also check that no result appears before two full rows have arrived, that the row-end flag only accompanies a valid result, and that a taken row-end result is followed by an idle output. The arithmetic cannot be seen by a property. The same holds for the border suppression pattern, the exact number of results and their order under mixed gaps and backpressure. The bench shows these by comparing a twelve-row stream against a model of both passes computed in the bench. The stream includes a saturated band of full-scale pixels.

// File: rtl/box_blur3x3.sv
module box_blur3x3 #(
  parameter int W  = 2000,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int SW = DW + 2;

  logic [CW-1:0] col;
  logic [1:0]    rows;
  logic [DW-1:0] p1, p2;
  logic [DW-1:0] row_a [W];
  logic [DW-1:0] row_b [W];
  logic [SW-1:0] hsum, vsum;
  logic [DW-1:0] hval;
  logic          take, row_end, interior;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign row_end  = (col == CW'(W - 1));
  assign interior = (col >= CW'(2)) && (rows == 2'd2);

  assign hsum = SW'(p2) + SW'(p1) + SW'(in_data);
  assign hval = DW'(hsum / SW'(3));
  assign vsum = SW'(row_b[col]) + SW'(row_a[col]) + SW'(hval);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col  <= '0;
      rows <= '0;
      p1   <= '0;
      p2   <= '0;
    end else if (take) begin
      p2  <= p1;
      p1  <= in_data;
      col <= row_end ? '0 : col + CW'(1);
      if (row_end && rows != 2'd2) rows <= rows + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      row_b[col] <= row_a[col];
      row_a[col] <= hval;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= interior;
      out_last  <= interior && row_end;
      out_data  <= DW'(vsum / SW'(3));
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R6

  AST_NO_EARLY_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rows == 2'd2); // R4

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R5

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last && out_ready |=> !out_valid); // R5

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    col <= CW'(W - 1)); // R8
endmodule

// File: tb/box_blur3x3_tb_top.sv
module box_blur3x3_tb_top;
  localparam int W  = 8;
  localparam int NR = 12;
  localparam int NI = W * NR;
  localparam int NE = (NR - 2) * (W - 2);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_last;

  int checks = 0;
  int errors = 0;
  int img [NR][W];
  int hv  [NR][W];
  int exp_d [NE];
  int exp_l [NE];
  int exp_y [NE];

  always #10 clk = ~clk;

  box_blur3x3 #(.W(W), .DW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k, ii, got, cyc;
    bit hold_pend;
    logic [15:0] hold_d;
    logic hold_l;
    logic [7:0] lfsr;
    for (int y = 0; y < NR; y++)
      for (int x = 0; x < W; x++)
        if (y >= 6 && y <= 9) img[y][x] = 65535;
        else img[y][x] = (x * 7919 + y * 30011 + x * y * 977) % 65536;
    for (int y = 0; y < NR; y++)
      for (int x = 1; x < W - 1; x++)
        hv[y][x] = (img[y][x-1] + img[y][x] + img[y][x+1]) / 3;
    k = 0;
    for (int y = 1; y < NR - 1; y++)
      for (int x = 1; x < W - 1; x++) begin
        exp_d[k] = (hv[y-1][x] + hv[y][x] + hv[y+1][x]) / 3;
        exp_l[k] = (x == W - 2) ? 1 : 0;
        exp_y[k] = y;
        k++;
      end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(out_last == 1'b0, "R1 out_last", int'(out_last), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    ii = 0; got = 0; cyc = 0; hold_pend = 0; lfsr = 8'h5a;
    hold_d = '0; hold_l = 1'b0;
    while ((ii < NI || out_valid) && cyc < 10000) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (ii < 4 * W) begin
        out_ready = 1'b1;
        in_valid = (ii < NI);
      end else begin
        out_ready = lfsr[0] | lfsr[3];
        in_valid = (ii < NI) && (lfsr[2] | lfsr[6]);
      end
      in_data = (ii < NI) ? 16'(img[ii / W][ii % W]) : 16'h0;
      #1;
      if (hold_pend) begin
        chk(out_valid && out_data == hold_d && out_last == hold_l,
            "R6 held output", int'(out_data), int'(hold_d));
      end
      chk(in_ready == (!out_valid || out_ready), "R7 in_ready",
          int'(in_ready), int'(!out_valid || out_ready));
      hold_pend = out_valid && !out_ready;
      hold_d = out_data;
      hold_l = out_last;
      if (out_valid && out_ready) begin
        if (got < NE) begin
          if (exp_y[got] >= 7 && exp_y[got] <= 8)
            chk(out_data == 16'(exp_d[got]), "R2 saturated data", int'(out_data), exp_d[got]);
          else
            chk(out_data == 16'(exp_d[got]), "R3 data", int'(out_data), exp_d[got]);
          chk(out_last == exp_l[got][0], "R5 last flag", int'(out_last), exp_l[got]);
        end else begin
          chk(1'b0, "R4 extra output", got, NE);
        end
        got++;
      end
      if (in_valid && in_ready) ii++;
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (5) begin
      #1;
      if (out_valid) got++;
      @(negedge clk);
    end
    chk(got == NE, "R4 output count", got, NE);
    chk(ii == NI, "R8 all rows accepted", ii, NI);
    chk(out_valid == 1'b0, "R5 idle after final row", int'(out_valid), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule